// File: doc/BRIEF.md
# Type-0 Configuration Header Register File

This block is the configuration space of a single-function bus target. It presents a 256-byte header organised as 32-bit doublewords. Identity fields come from parameters and are fixed. Three locations hold writable state: the command half-word, the first base address register and the interrupt line byte. The block sits behind the target's transaction claim logic. That logic supplies a latched address, a latched bus command, active-low byte enables and the active-low initiator-ready and target-ready strobes.

A data phase completes on a clock edge where both ready strobes are low. On such a phase a configuration write updates the enabled byte lanes of the writable fields at that edge. On such a phase a configuration read returns the addressed doubleword combinationally, in the same cycle. Any other bus command leaves the registers alone. Unimplemented and reserved offsets read as zero.

Top module: `cfg_hdr_space`

## Requirements
- R1: A synchronous active-low reset clears the command half-word, base register 0 and the interrupt line to zero. After reset, offset 0x04 reads 0x02000000, offset 0x10 reads 0 and offset 0x3C reads 0x08020100.
- R2: With default parameters the identity doublewords read as follows. Offset 0x00 reads 0x3C4D1A2B (device id in the upper half, vendor id in the lower half). Offset 0x08 reads 0x11800005 (class code in the upper three bytes, revision id in the low byte). Offset 0x2C reads 0x00011A2B. Offset 0x0C reads 0.
- R3: A write takes effect only on a clock edge where the command is 4'b1011 and both irdyN and trdyN are low. With either strobe high, nothing changes.
- R4: Commands other than 4'b1011 never modify any register. Examples are memory write 4'b0111, I/O write 4'b0011 and configuration read 4'b1010.
- R5: Byte enable bit i, active low, gates byte lane i (data bits 8i+7:8i). Enable pattern 4'b0000 writes all four lanes. Pattern 4'b1111 writes none.
- R6: Writes to offsets other than 0x04, 0x10 and 0x3C are ignored. Examples are 0x00, 0x08, 0x14 and 0x2C.
- R7: Only command bits 0, 1, 2, 6 and 8 are writable, and the other command bits read 0. The status half-word (bits 31:16 of 0x04) always reads 0x0200.
- R8: Base register 0 claims a memory region of 2^BAR_SIZE_LOG2 bytes. Its bits below BAR_SIZE_LOG2 read zero, bit 0 included. Writing all ones reads back 0xFFFFF000 with the default of 12.
- R9: Offset 0x3C reads {max latency 8'h08, min grant 8'h02, interrupt pin 8'h01, interrupt line}. Only the interrupt line byte (lane 0) is writable.
- R10: rdValid is high, and rdData carries the addressed doubleword, only when the command is 4'b1010 and both strobes are low; otherwise rdData is 0. The doubleword is selected by address bits 7:2. Offsets 0x14 to 0x28, 0x30 to 0x38 and 0x40 to 0xFC read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| addrLatched | input | 8 | Latched configuration byte address |
| cmdLatched | input | 4 | Latched bus command |
| beN | input | 4 | Active-low byte lane enables |
| irdyN | input | 1 | Initiator ready, active low |
| trdyN | input | 1 | Target ready, active low |
| wrData | input | 32 | Write data of the current data phase |
| rdData | output | 32 | Read data, zero when no read phase completes |
| rdValid | output | 1 | A configuration read phase completes this cycle |

## Verification
The bench builds the block with its default parameters. These are the identity values listed in R2, a 4 KB window for base register 0, and a status word of 0x0200. With these values every readback has one known constant. The 12-bit window lets the all-ones probe show the sizing boundary at bit 12. A byte-lane write to lane 3 of the base register shows that lane masking works together with the hardwired low bits.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int CFG_ADDR_W = 8;
  localparam int DW_SEL_W   = CFG_ADDR_W - 2;
  localparam int DATA_W     = 32;
  localparam int LANES      = DATA_W / 8;

  localparam logic [3:0] BUS_CFG_RD = 4'b1010;
  localparam logic [3:0] BUS_CFG_WR = 4'b1011;

  localparam logic [DW_SEL_W-1:0] DW_IDENT  = 6'd0;
  localparam logic [DW_SEL_W-1:0] DW_CMDSTS = 6'd1;
  localparam logic [DW_SEL_W-1:0] DW_CLASS  = 6'd2;
  localparam logic [DW_SEL_W-1:0] DW_MISC   = 6'd3;
  localparam logic [DW_SEL_W-1:0] DW_BAR0   = 6'd4;
  localparam logic [DW_SEL_W-1:0] DW_SUBSYS = 6'd11;
  localparam logic [DW_SEL_W-1:0] DW_INTR   = 6'd15;

  typedef struct packed {
    logic                wrCmd;
    logic                wrBar;
    logic                wrIntl;
    logic                rdEn;
    logic [LANES-1:0]    laneEn;
    logic [DW_SEL_W-1:0] dwSel;
  } cfgStrobe_t;

  function automatic logic [DATA_W-1:0] laneMerge(
    input logic [DATA_W-1:0] oldVal,
    input logic [DATA_W-1:0] newVal,
    input logic [LANES-1:0]  laneEn,
    input logic [DATA_W-1:0] wrMask
  );
    logic [DATA_W-1:0] bitEn;
    for (int i = 0; i < LANES; i++) begin
      bitEn[i*8 +: 8] = {8{laneEn[i]}};
    end
    bitEn = bitEn & wrMask;
    return (oldVal & ~bitEn) | (newVal & bitEn);
  endfunction
endpackage

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CFG_ADDR_W-1:0] addrLatched,
  input  logic [3:0]            cmdLatched,
  input  logic [LANES-1:0]      beN,
  input  logic                  irdyN,
  input  logic                  trdyN,
  output cfgStrobe_t            st
);
  logic phaseDone;
  logic cfgWr;
  logic [DW_SEL_W-1:0] dwSel;

  assign phaseDone = !irdyN && !trdyN;
  assign cfgWr     = phaseDone && (cmdLatched == BUS_CFG_WR);
  assign dwSel     = addrLatched[CFG_ADDR_W-1:2];

  always_comb begin
    st        = '0;
    st.dwSel  = dwSel;
    st.laneEn = ~beN;
    st.rdEn   = phaseDone && (cmdLatched == BUS_CFG_RD);
    if (cfgWr) begin
      unique case (dwSel)
        DW_CMDSTS: st.wrCmd  = 1'b1;
        DW_BAR0:   st.wrBar  = 1'b1;
        DW_INTR:   st.wrIntl = 1'b1;
        default:   ;
      endcase
    end
  end

  // R3
  wr_needs_handshake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrCmd || st.wrBar || st.wrIntl) |-> (!irdyN && !trdyN));

  // R4
  wr_cmd_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrCmd || st.wrBar || st.wrIntl) |-> (cmdLatched == BUS_CFG_WR));

  // R10
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.rdEn, st.wrCmd, st.wrBar, st.wrIntl}));
endmodule

// File: rtl/cfg_hdr_dpath.sv
module cfg_hdr_dpath
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID     = 16'h3C4D,
  parameter logic [7:0]  REVISION_ID   = 8'h05,
  parameter logic [23:0] CLASS_CODE    = 24'h118000,
  parameter logic [15:0] SUBSYS_VID    = 16'h1A2B,
  parameter logic [15:0] SUBSYS_ID     = 16'h0001,
  parameter logic [15:0] STATUS_VAL    = 16'h0200,
  parameter logic [7:0]  MIN_GNT       = 8'h02,
  parameter logic [7:0]  MAX_LAT       = 8'h08,
  parameter logic [7:0]  HDR_TYPE      = 8'h00,
  parameter int          BAR_SIZE_LOG2 = 12
)(
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        st,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam logic [15:0]       CMD_WMASK  = 16'h0147;
  localparam logic [DATA_W-1:0] BAR_WMASK  = ~((DATA_W'(1) << BAR_SIZE_LOG2) - DATA_W'(1));
  localparam logic [DATA_W-1:0] INTL_WMASK = 32'h0000_00FF;
  localparam logic [7:0]        INT_PIN    = 8'h01;

  logic [15:0]       cmdReg;
  logic [DATA_W-1:0] barReg;
  logic [7:0]        intLine;
  logic [DATA_W-1:0] cmdNext, barNext, intlNext;

  always_comb begin
    cmdNext  = laneMerge({16'h0, cmdReg}, wrData, st.laneEn, {16'h0, CMD_WMASK});
    barNext  = laneMerge(barReg, wrData, st.laneEn, BAR_WMASK);
    intlNext = laneMerge({24'h0, intLine}, wrData, st.laneEn, INTL_WMASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      barReg  <= '0;
      intLine <= '0;
    end else begin
      if (st.wrCmd)  cmdReg  <= cmdNext[15:0];
      if (st.wrBar)  barReg  <= barNext;
      if (st.wrIntl) intLine <= intlNext[7:0];
    end
  end

  always_comb begin
    rdData  = '0;
    rdValid = st.rdEn;
    if (st.rdEn) begin
      case (st.dwSel)
        DW_IDENT:  rdData = {DEVICE_ID, VENDOR_ID};
        DW_CMDSTS: rdData = {STATUS_VAL, cmdReg};
        DW_CLASS:  rdData = {CLASS_CODE, REVISION_ID};
        DW_MISC:   rdData = {8'h00, HDR_TYPE, 8'h00, 8'h00};
        DW_BAR0:   rdData = barReg;
        DW_SUBSYS: rdData = {SUBSYS_ID, SUBSYS_VID};
        DW_INTR:   rdData = {MAX_LAT, MIN_GNT, INT_PIN, intLine};
        default:   rdData = '0;
      endcase
    end
  end

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrCmd |=> $stable(cmdReg));
  // R3
  bar_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrBar |=> $stable(barReg));
  // R3
  intl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrIntl |=> $stable(intLine));
  // R7
  status_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && st.dwSel == DW_CMDSTS) |-> (rdData[31:16] == STATUS_VAL && (rdData[15:0] & ~CMD_WMASK) == 16'h0));
  // R8
  bar_low_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && st.dwSel == DW_BAR0) |-> (rdData[BAR_SIZE_LOG2-1:0] == '0));
  // R9
  int_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && st.dwSel == DW_INTR) |-> (rdData[15:8] == INT_PIN));
  // R10
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));
endmodule

// File: rtl/cfg_hdr_space.sv
module cfg_hdr_space
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID     = 16'h3C4D,
  parameter logic [7:0]  REVISION_ID   = 8'h05,
  parameter logic [23:0] CLASS_CODE    = 24'h118000,
  parameter logic [15:0] SUBSYS_VID    = 16'h1A2B,
  parameter logic [15:0] SUBSYS_ID     = 16'h0001,
  parameter logic [15:0] STATUS_VAL    = 16'h0200,
  parameter logic [7:0]  MIN_GNT       = 8'h02,
  parameter logic [7:0]  MAX_LAT       = 8'h08,
  parameter logic [7:0]  HDR_TYPE      = 8'h00,
  parameter int          BAR_SIZE_LOG2 = 12
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  addrLatched,
  input  logic [3:0]  cmdLatched,
  input  logic [3:0]  beN,
  input  logic        irdyN,
  input  logic        trdyN,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        rdValid
);
  cfgStrobe_t st;

  cfg_hdr_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .addrLatched (addrLatched),
    .cmdLatched  (cmdLatched),
    .beN         (beN),
    .irdyN       (irdyN),
    .trdyN       (trdyN),
    .st          (st)
  );

  cfg_hdr_dpath #(
    .VENDOR_ID     (VENDOR_ID),
    .DEVICE_ID     (DEVICE_ID),
    .REVISION_ID   (REVISION_ID),
    .CLASS_CODE    (CLASS_CODE),
    .SUBSYS_VID    (SUBSYS_VID),
    .SUBSYS_ID     (SUBSYS_ID),
    .STATUS_VAL    (STATUS_VAL),
    .MIN_GNT       (MIN_GNT),
    .MAX_LAT       (MAX_LAT),
    .HDR_TYPE      (HDR_TYPE),
    .BAR_SIZE_LOG2 (BAR_SIZE_LOG2)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdValid (rdValid)
  );
endmodule

// File: tb/tb_cfg_hdr_space.sv
module tb_cfg_hdr_space;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  addrLatched;
  logic [3:0]  cmdLatched;
  logic [3:0]  beN;
  logic        irdyN;
  logic        trdyN;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        rdValid;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_hdr_space dut (
    .clk(clk), .rstN(rstN), .addrLatched(addrLatched), .cmdLatched(cmdLatched),
    .beN(beN), .irdyN(irdyN), .trdyN(trdyN), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );

  typedef struct packed {
    logic [3:0]  cmd;
    logic [7:0]  addr;
    logic [3:0]  beN;
    logic        irdyN;
    logic        trdyN;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{4'hB, 8'h04, 4'h0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h02000147, 4'd7},  // R7
    '{4'hB, 8'h04, 4'hE, 1'b0, 1'b0, 32'h00000000, 32'h02000100, 4'd5},  // R5
    '{4'hB, 8'h04, 4'hD, 1'b0, 1'b0, 32'h00000000, 32'h02000000, 4'd5},  // R5
    '{4'hB, 8'h04, 4'h0, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h02000000, 4'd3},  // R3
    '{4'hB, 8'h04, 4'h0, 1'b0, 1'b1, 32'hFFFFFFFF, 32'h02000000, 4'd3},  // R3
    '{4'h7, 8'h04, 4'h0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h02000000, 4'd4},  // R4
    '{4'hA, 8'h3C, 4'h0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h08020100, 4'd4},  // R4
    '{4'hB, 8'h10, 4'h0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFF000, 4'd8},  // R8
    '{4'hB, 8'h10, 4'h7, 1'b0, 1'b0, 32'h12345678, 32'h12FFF000, 4'd5},  // R5
    '{4'hB, 8'h10, 4'hF, 1'b0, 1'b0, 32'h00000000, 32'h12FFF000, 4'd5},  // R5
    '{4'hB, 8'h3C, 4'h0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h080201FF, 4'd9},  // R9
    '{4'hB, 8'h3C, 4'hE, 1'b0, 1'b0, 32'h0000005A, 32'h0802015A, 4'd9},  // R9
    '{4'hB, 8'h00, 4'h0, 1'b0, 1'b0, 32'h00000000, 32'h3C4D1A2B, 4'd6},  // R6
    '{4'hB, 8'h08, 4'h0, 1'b0, 1'b0, 32'h00000000, 32'h11800005, 4'd6},  // R6
    '{4'hB, 8'h14, 4'h0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000000, 4'd6},  // R6
    '{4'hB, 8'h2C, 4'h0, 1'b0, 1'b0, 32'h00000000, 32'h00011A2B, 4'd6},  // R6
    '{4'hB, 8'h40, 4'h0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000000, 4'd10}, // R10
    '{4'h3, 8'h04, 4'h0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h02000000, 4'd4}   // R4
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic goIdle();
    cmdLatched = 4'h0; irdyN = 1'b1; trdyN = 1'b1; beN = 4'hF; wrData = '0; addrLatched = '0;
  endtask

  // starts just after a falling edge, ends just after the next falling edge
  task automatic busPhase(input logic [3:0] cmd, input logic [7:0] addr, input logic [3:0] be,
                          input logic ir, input logic tr, input logic [31:0] d);
    cmdLatched = cmd; addrLatched = addr; beN = be; irdyN = ir; trdyN = tr; wrData = d;
    @(posedge clk);
    @(negedge clk);
    goIdle();
  endtask

  task automatic readCheck(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    cmdLatched = 4'hA; addrLatched = addr; beN = 4'h0; irdyN = 1'b0; trdyN = 1'b0;
    #1;
    check({31'h0, rdValid}, 32'h1, {tag, " rdValid"});
    check(rdData, exp, tag);
    @(posedge clk);
    @(negedge clk);
    goIdle();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    goIdle();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readCheck(8'h04, 32'h02000000, "R1");
    readCheck(8'h10, 32'h00000000, "R1");
    readCheck(8'h3C, 32'h08020100, "R1");
    // R2 identity
    readCheck(8'h00, 32'h3C4D1A2B, "R2");
    readCheck(8'h08, 32'h11800005, "R2");
    readCheck(8'h2C, 32'h00011A2B, "R2");
    readCheck(8'h0C, 32'h00000000, "R2");
    // R10 unimplemented offsets
    readCheck(8'h28, 32'h00000000, "R10");
    readCheck(8'h30, 32'h00000000, "R10");
    readCheck(8'hFC, 32'h00000000, "R10");

    for (int i = 0; i < NVEC; i++) begin
      busPhase(VECS[i].cmd, VECS[i].addr, VECS[i].beN, VECS[i].irdyN, VECS[i].trdyN, VECS[i].data);
      readCheck(VECS[i].addr, VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R10 byte address within a doubleword selects the same doubleword
    readCheck(8'h3E, 32'h0802015A, "R10");

    // R10 read with target not ready: no valid, zero data
    cmdLatched = 4'hA; addrLatched = 8'h00; irdyN = 1'b0; trdyN = 1'b1;
    #1;
    check({31'h0, rdValid}, 32'h0, "R10 stalled rdValid");
    check(rdData, 32'h0, "R10 stalled rdData");
    @(posedge clk);
    @(negedge clk);
    goIdle();

    // R1 reset during operation clears the writable fields
    busPhase(4'hB, 8'h04, 4'h0, 1'b0, 1'b0, 32'h00000007);
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    readCheck(8'h04, 32'h02000000, "R1 mid");
    readCheck(8'h10, 32'h00000000, "R1 mid");
    readCheck(8'h3C, 32'h08020100, "R1 mid");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule